// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block watches a digitised supply-voltage sample once per clock and decides which mode a battery-backed static memory is in. It drives the write-protect, input-ignore and output high-impedance flags, chooses between the external supply and the backup cell, and gates the external chip-enable request so that the array is never touched while the supply is out of tolerance. The sample is an unsigned code in 10 mV steps. Every threshold is a parameter in that unit.

The supervisor uses a four-level ladder. The highest level allows normal operation. A lower level forces protection, which gives hysteresis against the normal level. A still lower level switches in the backup cell. A trip level breaks a one-time shipping seal: until the supply first passes that level, the backup cell stays disconnected whatever the sample shows. A threshold crossing moves the mode only after it has held for a run of consecutive samples. An ordinary reset keeps the seal broken. Only the factory reseal input restores the seal.

Top module: `pwr_guard`

## Requirements
- R1: A clock edge with `reseal_i` high puts the block in the sealed mode, with `status_o` = 0, `bat_on_o` = 0 and all three protection flags high.
- R2: While sealed, the seal breaks only after FILT_LEN consecutive samples above TRIP_CODE. `status_o` then reads PROTECTED (2). A shorter run has no effect.
- R3: PROTECTED moves to NORMAL (1) only after FILT_LEN consecutive samples above NORM_CODE. An interrupted run restarts the count.
- R4: NORMAL moves to PROTECTED after FILT_LEN consecutive samples at or below WP_CODE. Samples between WP_CODE and NORM_CODE leave NORMAL unchanged.
- R5: PROTECTED moves to BACKUP (3) after FILT_LEN consecutive samples below BAT_CODE. `bat_on_o` is high and `ext_sel_o` is low in BACKUP and in no other mode.
- R6: BACKUP leaves only for PROTECTED, after FILT_LEN consecutive samples above BAT_CODE. A sample equal to BAT_CODE keeps BACKUP.
- R7: `wp_o`, `in_ign_o` and `out_hiz_o` are high in every mode except NORMAL, and low in NORMAL.
- R8: `ce_o` follows `ce_req_i` only in NORMAL. It is low in the first cycle that `status_o` shows any other mode.
- R9: Asserting `rst_ni` gives PROTECTED if the seal was already broken and sealed if it was not. The reset does not change the seal.
- R10: While sealed, samples below BAT_CODE never raise `bat_on_o`.
- R11: `status_o` encodes the modes as sealed = 0, NORMAL = 1, PROTECTED = 2 and BACKUP = 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one supply sample per edge |
| rst_ni | input | 1 | Asynchronous active-low reset; keeps the seal state |
| reseal_i | input | 1 | Synchronous factory reseal |
| sample_i | input | CODE_W | Supply sample, unsigned, 10 mV per LSB |
| ce_req_i | input | 1 | Chip-enable request from the host, active high |
| status_o | output | 2 | Current mode |
| wp_o | output | 1 | Write protect |
| in_ign_o | output | 1 | Memory-side inputs ignored |
| out_hiz_o | output | 1 | Data outputs held high-impedance |
| bat_on_o | output | 1 | Backup cell connected to the array |
| ext_sel_o | output | 1 | External supply selected |
| ce_o | output | 1 | Gated chip-enable, active high |

## Verification
The bench uses the default parameters. These are a 9-bit code, thresholds of 300, 280, 250 and 290, and a filter run of 4. With these values each threshold can be hit exactly, one code on either side, within a few samples. Runs of three qualifying samples followed by a dip test the restart of the filter count. Samples held between the protect and normal levels test the hysteresis band. Samples equal to the backup level test the strict comparisons. Resets taken while armed, and again while sealed, show that the seal survives an ordinary reset.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  typedef enum logic [1:0] {
    M_SEALED = 2'd0,
    M_NORMAL = 2'd1,
    M_PROT   = 2'd2,
    M_BACKUP = 2'd3
  } mode_e;
endpackage

// File: rtl/pwr_guard_cmp.sv
module pwr_guard_cmp #(
  parameter int CODE_W    = 9,
  parameter int NORM_CODE = 300,
  parameter int WP_CODE   = 280,
  parameter int BAT_CODE  = 250,
  parameter int TRIP_CODE = 290
) (
  input  logic [CODE_W-1:0] sample_i,
  output logic              above_norm_o,
  output logic              at_wp_o,
  output logic              below_bat_o,
  output logic              above_bat_o,
  output logic              above_trip_o
);
  localparam logic [CODE_W-1:0] NormC = CODE_W'(NORM_CODE);
  localparam logic [CODE_W-1:0] WpC   = CODE_W'(WP_CODE);
  localparam logic [CODE_W-1:0] BatC  = CODE_W'(BAT_CODE);
  localparam logic [CODE_W-1:0] TripC = CODE_W'(TRIP_CODE);

  assign above_norm_o = sample_i > NormC;
  assign at_wp_o      = sample_i <= WpC;
  assign below_bat_o  = sample_i < BatC;
  assign above_bat_o  = sample_i > BatC;
  assign above_trip_o = sample_i > TripC;
endmodule

// File: rtl/pwr_guard_filt.sv
module pwr_guard_filt #(
  parameter int FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic hit_i,
  output logic fire_o
);
  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] Last = CNT_W'(FILT_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  assign fire_o = hit_i && (cnt_q == Last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i || !hit_i || fire_o) cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pwr_guard_pkg::*;
#(
  parameter int CODE_W    = 9,
  parameter int NORM_CODE = 300,
  parameter int WP_CODE   = 280,
  parameter int BAT_CODE  = 250,
  parameter int TRIP_CODE = 290,
  parameter int FILT_LEN  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reseal_i,
  input  logic [CODE_W-1:0] sample_i,
  input  logic              ce_req_i,
  output logic [1:0]        status_o,
  output logic              wp_o,
  output logic              in_ign_o,
  output logic              out_hiz_o,
  output logic              bat_on_o,
  output logic              ext_sel_o,
  output logic              ce_o
);
  logic  above_norm, at_wp, below_bat, above_bat, above_trip;
  logic  up_hit, dn_hit, up_fire, dn_fire, step;
  logic  armed_q;
  mode_e mode_q, eff_mode;

  pwr_guard_cmp #(
    .CODE_W(CODE_W), .NORM_CODE(NORM_CODE), .WP_CODE(WP_CODE),
    .BAT_CODE(BAT_CODE), .TRIP_CODE(TRIP_CODE)
  ) u_cmp (
    .sample_i    (sample_i),
    .above_norm_o(above_norm),
    .at_wp_o     (at_wp),
    .below_bat_o (below_bat),
    .above_bat_o (above_bat),
    .above_trip_o(above_trip)
  );

  assign eff_mode = armed_q ? mode_q : M_SEALED;

  // rising and falling requests are filtered separately
  always_comb begin
    up_hit = 1'b0;
    dn_hit = 1'b0;
    unique case (eff_mode)
      M_SEALED: up_hit = above_trip;
      M_NORMAL: dn_hit = at_wp;
      M_PROT: begin
        up_hit = above_norm;
        dn_hit = below_bat;
      end
      M_BACKUP: up_hit = above_bat;
      default: ;
    endcase
  end

  assign step = up_fire || dn_fire || reseal_i;

  pwr_guard_filt #(.FILT_LEN(FILT_LEN)) u_up (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(step), .hit_i(up_hit), .fire_o(up_fire)
  );
  pwr_guard_filt #(.FILT_LEN(FILT_LEN)) u_dn (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(step), .hit_i(dn_hit), .fire_o(dn_fire)
  );

  // seal state survives rst_ni; only a factory reseal clears it
  always_ff @(posedge clk_i) begin
    if (reseal_i)                armed_q <= 1'b0;
    else if (!armed_q && up_fire) armed_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= M_PROT;
    else if (reseal_i) mode_q <= M_PROT;
    else if (armed_q) begin
      if (up_fire) begin
        if (mode_q == M_PROT)        mode_q <= M_NORMAL;
        else if (mode_q == M_BACKUP) mode_q <= M_PROT;
      end else if (dn_fire) begin
        if (mode_q == M_NORMAL)      mode_q <= M_PROT;
        else if (mode_q == M_PROT)   mode_q <= M_BACKUP;
      end
    end
  end

  logic run_ok;
  assign run_ok    = (eff_mode == M_NORMAL);
  assign status_o  = eff_mode;
  assign wp_o      = !run_ok;
  assign in_ign_o  = !run_ok;
  assign out_hiz_o = !run_ok;
  assign bat_on_o  = (eff_mode == M_BACKUP);
  assign ext_sel_o = (eff_mode != M_BACKUP);
  assign ce_o      = ce_req_i && run_ok;
endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk #(
  parameter int CODE_W    = 9,
  parameter int NORM_CODE = 300,
  parameter int WP_CODE   = 280,
  parameter int BAT_CODE  = 250,
  parameter int TRIP_CODE = 290
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reseal_i,
  input logic [CODE_W-1:0] sample_i,
  input logic              ce_req_i,
  input logic [1:0]        status_o,
  input logic              wp_o,
  input logic              bat_on_o,
  input logic              ext_sel_o,
  input logic              ce_o
);
  // R1
  reseal_seals_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reseal_i |=> (status_o == 2'd0 && !bat_on_o));
  // R2
  seal_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd0 && !reseal_i && sample_i <= CODE_W'(TRIP_CODE)) |=> status_o == 2'd0);
  // R3
  no_early_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd2 && !reseal_i && sample_i <= CODE_W'(NORM_CODE)) |=> status_o != 2'd1);
  // R4
  normal_band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd1 && !reseal_i && sample_i > CODE_W'(WP_CODE)) |=> status_o == 2'd1);
  // R5
  bat_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_on_o |-> (status_o == 2'd3 && !ext_sel_o && wp_o));
  // R6
  backup_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd3 && !reseal_i) |=> (status_o == 2'd3 || status_o == 2'd2));
  // R8
  ce_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o |-> (ce_req_i && status_o == 2'd1 && !wp_o));
  // R10
  sealed_no_bat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd0) |-> !bat_on_o);
endmodule

bind pwr_guard pwr_guard_chk #(
  .CODE_W(CODE_W), .NORM_CODE(NORM_CODE), .WP_CODE(WP_CODE),
  .BAT_CODE(BAT_CODE), .TRIP_CODE(TRIP_CODE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reseal_i(reseal_i), .sample_i(sample_i),
  .ce_req_i(ce_req_i), .status_o(status_o), .wp_o(wp_o), .bat_on_o(bat_on_o),
  .ext_sel_o(ext_sel_o), .ce_o(ce_o)
);

// File: tb/pwr_guard_bench.sv
`timescale 1ns/1ps
module pwr_guard_bench;
  localparam int CW = 9;
  localparam int NORM = 300, WP = 280, BAT = 250, TRIP = 290, RUN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reseal = 1'b1;
  logic [CW-1:0] smp = '0;
  logic ce_req = 1'b0;
  logic [1:0] status;
  logic wp, ign, hiz, bat, ext, ce;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int m_mode = 2;
  bit m_armed = 1'b0;
  int m_up = 0, m_dn = 0;

  always #4 clk = ~clk;

  pwr_guard u_pwr_guard (
    .clk_i(clk), .rst_ni(rst_n), .reseal_i(reseal), .sample_i(smp),
    .ce_req_i(ce_req), .status_o(status), .wp_o(wp), .in_ign_o(ign),
    .out_hiz_o(hiz), .bat_on_o(bat), .ext_sel_o(ext), .ce_o(ce)
  );

  function automatic int eff();
    return m_armed ? m_mode : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    int e = eff();
    chk("R11 status", int'(status), e);
    chk("R7 wp", int'(wp), int'(e != 1));
    chk("R7 in_ign", int'(ign), int'(e != 1));
    chk("R7 out_hiz", int'(hiz), int'(e != 1));
    chk("R5 bat_on", int'(bat), int'(e == 3));
    chk("R5 ext_sel", int'(ext), int'(e != 3));
    chk("R8 ce", int'(ce), int'(ce_req && e == 1));
  endtask

  task automatic model_edge(input int s);
    int e;
    bit uh, dh;
    if (!rst_n) return;
    if (reseal) begin
      m_armed = 1'b0; m_mode = 2; m_up = 0; m_dn = 0;
      return;
    end
    e = eff();
    uh = (e == 0 && s > TRIP) || (e == 2 && s > NORM) || (e == 3 && s > BAT);
    dh = (e == 1 && s <= WP) || (e == 2 && s < BAT);
    m_up = uh ? m_up + 1 : 0;
    m_dn = dh ? m_dn + 1 : 0;
    if (m_up == RUN) begin
      if (!m_armed) m_armed = 1'b1;
      else if (m_mode == 2) m_mode = 1;
      else if (m_mode == 3) m_mode = 2;
      m_up = 0; m_dn = 0;
    end else if (m_dn == RUN) begin
      if (m_mode == 1) m_mode = 2;
      else if (m_mode == 2) m_mode = 3;
      m_up = 0; m_dn = 0;
    end
  endtask

  task automatic tick(input int s);
    smp = CW'(s);
    @(posedge clk);
    model_edge(s);
    #2;
    cmp_all();
  endtask

  task automatic ticks(input int s, input int n);
    for (int i = 0; i < n; i++) tick(s);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_mode = 2; m_up = 0; m_dn = 0;
    #2;
    cmp_all();
    @(posedge clk);
    #2;
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // reset with reseal held: sealed
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    tick(100);
    m_armed = 1'b0;
    chk("R1 sealed after reseal", int'(status), 0);
    chk("R1 bat off after reseal", int'(bat), 0);
    reseal = 1'b0;
    ce_req = 1'b1;
    // R10: sealed, low supply, no battery
    ticks(100, 6);
    chk("R10 no bat while sealed", int'(bat), 0);
    // R2: short run then full run above trip
    ticks(295, 3);
    tick(290);
    chk("R2 short run keeps seal", int'(status), 0);
    ticks(295, 3);
    chk("R2 still sealed after 3", int'(status), 0);
    tick(295);
    chk("R2 armed to PROTECTED", int'(status), 2);
    // R3: interrupted run, then full run
    ticks(310, 3);
    tick(300);
    chk("R3 interrupted run", int'(status), 2);
    ticks(301, 4);
    chk("R3 NORMAL reached", int'(status), 1);
    chk("R8 ce passes in NORMAL", int'(ce), 1);
    // R4: hysteresis band then drop
    ticks(281, 6);
    chk("R4 band holds NORMAL", int'(status), 1);
    ticks(280, 3);
    chk("R4 three low keep NORMAL", int'(status), 1);
    tick(280);
    chk("R4 PROTECTED", int'(status), 2);
    chk("R8 ce blocked first cycle", int'(ce), 0);
    // R5: drop to backup
    ticks(249, 4);
    chk("R5 BACKUP", int'(status), 3);
    chk("R5 bat on", int'(bat), 1);
    chk("R5 ext off", int'(ext), 0);
    // R6: equal to level holds, then climb via PROTECTED only
    ticks(250, 6);
    chk("R6 equal holds BACKUP", int'(status), 3);
    ticks(320, 4);
    chk("R6 exits to PROTECTED", int'(status), 2);
    ticks(320, 4);
    chk("R3 then NORMAL", int'(status), 1);
    // R9: reset while armed
    do_reset();
    chk("R9 armed reset gives PROTECTED", int'(status), 2);
    ticks(320, 4);
    chk("R9 seal kept across reset", int'(status), 1);
    ce_req = 1'b0;
    tick(320);
    chk("R8 ce follows request", int'(ce), 0);
    // reseal then reset while sealed
    reseal = 1'b1;
    tick(320);
    reseal = 1'b0;
    chk("R1 reseal from NORMAL", int'(status), 0);
    do_reset();
    chk("R9 sealed reset stays sealed", int'(status), 0);
    ticks(200, 5);
    chk("R10 sealed low no bat", int'(bat), 0);
    ticks(291, 4);
    chk("R2 re-armed", int'(status), 2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule